// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers up to 32 asynchronous interrupt lines into one interrupt request for a processor or for a parent controller. Each line is brought into the clock domain through a flop chain. It is then judged by its own trigger setting: level-sensitive or edge-sensitive, active-high/rising or active-low/falling. Edge events are held in a latch until software clears them by writing a one to the matching bit. Level events track the input directly.

Software reaches the block through a simple synchronous register port. A write takes effect at the clock edge on which the write strobe is high. A read returns its data on the cycle after the read strobe. The masked status register lists every pending source that is enabled. Software services these starting from the lowest set bit. The combined output is a registered OR of the status, so one instance can drive one input line of another instance when controllers are cascaded.

Top module: `irq_trig_ctrl`

## Requirements
- R1: After reset the enable, polarity and type registers read zero, the status register reads zero and `irq_out` is low. Every source therefore starts disabled, level-triggered and active-low, so the raw register reads all ones while the inputs are low.
- R2: Byte offsets on `reg_addr` decode as follows.
  - 0x00: enable, read/write.
  - 0x04: raw, read and write-one-to-clear.
  - 0x08: masked status, read-only.
  - 0x0C: polarity, read/write.
  - 0x10: type, read/write.
  - Offset 0x14 and every other offset read as zero.
  - Read data appears on `reg_rdata` one clock after the edge that samples `reg_rd`.
- R3: Status bit n equals raw bit n AND enable bit n. A source whose enable bit is 0 reaches neither the status register nor `irq_out`.
- R4: With type bit n = 0 (level), raw bit n equals the synchronised input when polarity bit n = 1, and its inverse when polarity bit n = 0.
- R5: With type bit n = 1 (edge), raw bit n sets on a rising input edge when polarity bit n = 1, or on a falling edge when it is 0. The bit stays set after the input returns to its idle level.
- R6: Writing 1 to raw bit n clears a latched edge event. Writing 0 leaves it unchanged.
- R7: When an edge is detected in the same cycle as a clear write to that bit, the bit ends set.
- R8: `irq_out` is the registered OR of all status bits. A level input change driven between clock edges shows on `irq_out` after the third following rising edge.
- R9: Bit n of every register and of `irq_src` refers to source n only. Sources do not interact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W (5) | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, one cycle after `reg_rd` |
| irq_src | input | NUM_SRC (32) | Asynchronous interrupt inputs |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A stuck or stale edge latch shows up in the raw register at the next read. It also shows on `irq_out` within one cycle of the source being enabled. A wrong polarity or type decode inverts a level source's raw bit two cycles after the input moves. A clear that beats a simultaneous edge loses that event for good: the raw bit reads zero although the input did move. The bench drives all four trigger modes across mixed bit patterns, times the three-edge path to `irq_out`, and lines up an edge exactly against a clear write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // register byte offsets; software depends on these
   localparam int unsigned OFS_ENABLE = 32'h00;
   localparam int unsigned OFS_RAW    = 32'h04;
   localparam int unsigned OFS_STATUS = 32'h08;
   localparam int unsigned OFS_POLAR  = 32'h0C;
   localparam int unsigned OFS_KIND   = 32'h10;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ENABLE,
      SEL_RAW,
      SEL_STATUS,
      SEL_POLAR,
      SEL_KIND
   } reg_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irqc_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("irqc_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   input  logic pol,
   input  logic kind,
   input  logic clr,
   output logic hit,
   output logic latch,
   output logic raw
);
   logic prev_q;
   logic act;
   logic prev_act;
   logic latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_in;
   end

   // polarity-adjusted view of current and previous sample
   assign act      = pol ? lvl_in : ~lvl_in;
   assign prev_act = pol ? prev_q : ~prev_q;
   assign hit      = act & ~prev_act;

   // edge latch: a fresh event outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= 1'b0;
      else        latch_q <= kind & (hit | (latch_q & ~clr));
   end

   assign latch = latch_q;
   assign raw   = kind ? latch_q : act;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr,
   input  logic               rd,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] raw,
   output logic [DATA_W-1:0]  rdata,
   output logic [NUM_SRC-1:0] ena,
   output logic [NUM_SRC-1:0] pol,
   output logic [NUM_SRC-1:0] kind,
   output logic [NUM_SRC-1:0] clr,
   output logic [NUM_SRC-1:0] sts
);
   localparam int MIN_ADDR_W = $clog2(OFS_KIND + 1);

   generate
      if (NUM_SRC > DATA_W) begin : g_bad_src
         $error("irqc_regs: NUM_SRC exceeds DATA_W");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("irqc_regs: ADDR_W too narrow for register map");
      end
   endgenerate

   reg_sel_e             sel;
   logic [NUM_SRC-1:0]   wbits;
   logic [NUM_SRC-1:0]   ena_q;
   logic [NUM_SRC-1:0]   pol_q;
   logic [NUM_SRC-1:0]   kind_q;
   logic [DATA_W-1:0]    rmux;
   logic [DATA_W-1:0]    rdata_q;

   always_comb begin
      sel = SEL_NONE;
      if      (addr == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
      else if (addr == ADDR_W'(OFS_RAW))    sel = SEL_RAW;
      else if (addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
      else if (addr == ADDR_W'(OFS_POLAR))  sel = SEL_POLAR;
      else if (addr == ADDR_W'(OFS_KIND))   sel = SEL_KIND;
   end

   assign wbits = wdata[NUM_SRC-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q  <= '0;
         pol_q  <= '0;
         kind_q <= '0;
      end else if (wr) begin
         if (sel == SEL_ENABLE) ena_q  <= wbits;
         if (sel == SEL_POLAR)  pol_q  <= wbits;
         if (sel == SEL_KIND)   kind_q <= wbits;
      end
   end

   assign clr = (wr && sel == SEL_RAW) ? wbits : '0;
   assign sts = raw & ena_q;

   always_comb begin
      unique case (sel)
         SEL_ENABLE: rmux = DATA_W'(ena_q);
         SEL_RAW:    rmux = DATA_W'(raw);
         SEL_STATUS: rmux = DATA_W'(sts);
         SEL_POLAR:  rmux = DATA_W'(pol_q);
         SEL_KIND:   rmux = DATA_W'(kind_q);
         default:    rmux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata_q <= '0;
      else if (rd) rdata_q <= rmux;
   end

   assign rdata = rdata_q;
   assign ena   = ena_q;
   assign pol   = pol_q;
   assign kind  = kind_q;
endmodule

// File: rtl/irq_trig_ctrl.sv
module irq_trig_ctrl #(
   parameter int NUM_SRC     = 32,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] irq_src,
   output logic               irq_out
);
   generate
      if (NUM_SRC < 1) begin : g_bad_n
         $error("irq_trig_ctrl: NUM_SRC must be at least 1");
      end
   endgenerate

   logic [NUM_SRC-1:0] sync_lvl;
   logic [NUM_SRC-1:0] ena_q;
   logic [NUM_SRC-1:0] pol_q;
   logic [NUM_SRC-1:0] kind_q;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] hit_vec;
   logic [NUM_SRC-1:0] latch_vec;
   logic [NUM_SRC-1:0] raw_vec;
   logic [NUM_SRC-1:0] sts_vec;
   logic               irq_q;

   irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_src),
      .q     (sync_lvl)
   );

   generate
      for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
         irqc_src_cell cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_in (sync_lvl[n]),
            .pol    (pol_q[n]),
            .kind   (kind_q[n]),
            .clr    (clr_vec[n]),
            .hit    (hit_vec[n]),
            .latch  (latch_vec[n]),
            .raw    (raw_vec[n])
         );
      end
   endgenerate

   irqc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (reg_addr),
      .wr    (reg_wr),
      .rd    (reg_rd),
      .wdata (reg_wdata),
      .raw   (raw_vec),
      .rdata (reg_rdata),
      .ena   (ena_q),
      .pol   (pol_q),
      .kind  (kind_q),
      .clr   (clr_vec),
      .sts   (sts_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |sts_vec;
   end

   assign irq_out = irq_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int N = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] sync_lvl,
   input logic [N-1:0] ena,
   input logic [N-1:0] pol,
   input logic [N-1:0] kind,
   input logic [N-1:0] clr,
   input logic [N-1:0] hit,
   input logic [N-1:0] latch,
   input logic [N-1:0] raw,
   input logic [N-1:0] sts,
   input logic         irq_out
);
   AST_RESET_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ena == '0 && pol == '0 && kind == '0 && !irq_out)); // R1

   AST_STATUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (sts & ~ena) == '0); // R3

   AST_OUT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(ena) != '0); // R8

   AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (~kind & (raw ^ (pol ~^ sync_lvl))) == '0); // R4

   AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(latch & ~clr & kind) & kind & ~latch) == '0)); // R5

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr & ~hit) != '0 |=> (($past(clr & ~hit) & latch) == '0)); // R6

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit & kind) != '0 |=> (($past(hit & kind) & ~latch) == '0)); // R7
endmodule

bind irq_trig_ctrl irqc_chk #(.N(NUM_SRC)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .sync_lvl (sync_lvl),
   .ena      (ena_q),
   .pol      (pol_q),
   .kind     (kind_q),
   .clr      (clr_vec),
   .hit      (hit_vec),
   .latch    (latch_vec),
   .raw      (raw_vec),
   .sts      (sts_vec),
   .irq_out  (irq_out)
);

// File: tb/irq_trig_ctrl_tb_top.sv
module irq_trig_ctrl_tb_top;
   localparam logic [4:0] A_ENA  = 5'h00;
   localparam logic [4:0] A_RAW  = 5'h04;
   localparam logic [4:0] A_STS  = 5'h08;
   localparam logic [4:0] A_POL  = 5'h0C;
   localparam logic [4:0] A_KIND = 5'h10;
   localparam logic [4:0] A_RSV  = 5'h14;

   typedef struct packed {
      logic [31:0] pol;
      logic [31:0] kind;
      logic [31:0] ena;
      logic [31:0] in0;
      logic [31:0] in1;
      logic [31:0] exp_raw;
      logic [31:0] exp_sts;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      // level high, mixed pattern (R4, R9)
      '{32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
      // level low, half enabled (R4, R3)
      '{32'h0, 32'h0, 32'hFFFF_0000, 32'h0, 32'h0000_FFFF, 32'hFFFF_0000, 32'hFFFF_0000},
      // rising edge (R5)
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0F0F_0F0F, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
      // falling edge, partial enable (R5, R3)
      '{32'h0, 32'hFFFF_FFFF, 32'h00FF_00FF, 32'hFFFF_FFFF, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h000F_000F},
      // mixed: low half falling edge, high half level high (R9)
      '{32'hFFFF_0000, 32'h0000_FFFF, 32'h0000_00FF, 32'h0000_FFFF, 32'h1234_0000, 32'h1234_FFFF, 32'h0000_00FF},
      // edge mode, no transition (R5)
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0},
      // all masked (R3)
      '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h8000_0001, 32'h8000_0001, 32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] irq_src = '0;
   logic        irq_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   irq_trig_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_src   (irq_src),
      .irq_out   (irq_out)
   );

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(A_ENA, v);  check("R1 enable after reset", v, 32'h0);
      rd(A_POL, v);  check("R1 polarity after reset", v, 32'h0);
      rd(A_KIND, v); check("R1 type after reset", v, 32'h0);
      rd(A_RAW, v);  check("R1 raw all ones with low inputs", v, 32'hFFFF_FFFF);
      rd(A_STS, v);  check("R1 status after reset", v, 32'h0);
      check("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);

      // R2 map: reserved offsets, readback
      rd(A_RSV, v);  check("R2 offset 0x14 reads zero", v, 32'h0);
      rd(5'h18, v);  check("R2 unmapped offset reads zero", v, 32'h0);
      wr(A_POL, 32'h1357_9BDF);
      rd(A_POL, v);  check("R2 polarity readback", v, 32'h1357_9BDF);
      wr(A_POL, 32'h0);

      // vector table (R3 R4 R5 R9)
      for (int i = 0; i < NV; i++) begin
         wr(A_POL, VECS[i].pol);
         wr(A_KIND, VECS[i].kind);
         wr(A_ENA, VECS[i].ena);
         @(negedge clk); irq_src = VECS[i].in0;
         idle(6);
         wr(A_RAW, 32'hFFFF_FFFF);
         @(negedge clk); irq_src = VECS[i].in1;
         idle(6);
         rd(A_RAW, v); check($sformatf("R4 R5 R9 vector %0d raw", i), v, VECS[i].exp_raw);
         rd(A_STS, v); check($sformatf("R3 vector %0d status", i), v, VECS[i].exp_sts);
         check($sformatf("R8 vector %0d irq_out", i), {31'b0, irq_out},
               {31'b0, |VECS[i].exp_sts});
      end

      // R5 edge holds after the input returns to idle
      wr(A_ENA, 32'h0);
      @(negedge clk); irq_src = 32'h0;
      wr(A_POL, 32'h0000_0008);
      wr(A_KIND, 32'h0000_0008);
      idle(6);
      wr(A_RAW, 32'hFFFF_FFFF);
      @(negedge clk); irq_src[3] = 1'b1;
      idle(5);
      @(negedge clk); irq_src[3] = 1'b0;
      idle(5);
      rd(A_RAW, v); check("R5 edge latch held, bit 3", v & 32'h8, 32'h8);

      // R6 write zero leaves latch, write one clears
      wr(A_RAW, 32'h0);
      rd(A_RAW, v); check("R6 write 0 keeps latch", v & 32'h8, 32'h8);
      wr(A_RAW, 32'h8);
      rd(A_RAW, v); check("R6 write 1 clears latch", v & 32'h8, 32'h0);

      // R7 edge and clear meet at the same clock edge
      wr(A_POL, 32'h0000_0020);
      wr(A_KIND, 32'h0000_0020);
      idle(4);
      wr(A_RAW, 32'h20);
      @(negedge clk); irq_src[5] = 1'b1;      // sync stage 1 at next edge
      @(negedge clk);                         // stage 2 at next edge, hit follows
      @(negedge clk);
      reg_addr = A_RAW; reg_wdata = 32'h20; reg_wr = 1'b1;   // clear on latch edge
      @(negedge clk);
      reg_wr = 1'b0;
      rd(A_RAW, v); check("R7 set wins over clear, bit 5", v & 32'h20, 32'h20);

      // R8 latency: level high source 9, enabled alone
      wr(A_KIND, 32'h0);
      wr(A_POL, 32'h0000_0200);
      wr(A_ENA, 32'h0000_0200);
      @(negedge clk); irq_src = 32'h0;
      idle(6);
      check("R8 irq_out idle before change", {31'b0, irq_out}, 32'h0);
      @(negedge clk); irq_src[9] = 1'b1;
      @(negedge clk); check("R8 irq_out low after edge 1", {31'b0, irq_out}, 32'h0);
      @(negedge clk); check("R8 irq_out low after edge 2", {31'b0, irq_out}, 32'h0);
      @(negedge clk); check("R8 irq_out high after edge 3", {31'b0, irq_out}, 32'h1);

      // R3 disabling drops the output
      wr(A_ENA, 32'h0);
      idle(2);
      check("R3 irq_out low once disabled", {31'b0, irq_out}, 32'h0);

      // R1 reset mid-run restores defaults
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
      rd(A_KIND, v); check("R1 type cleared by reset", v, 32'h0);
      rd(A_POL, v);  check("R1 polarity cleared by reset", v, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule